// File: doc/BRIEF.md
# Serial Combination Lock Controller

This block is the control state machine of a two-button digital padlock. Every button press reaches it as a single-cycle strobe, together with one bit that names the button pressed. The machine steps once per strobe and ignores every cycle that has no strobe. It asserts its open output whenever the three most recent presses form the sequence 1 then 0 then 0.

The machine is a Moore machine. It keeps a two-bit state: no progress (00), seen 1 (01), seen 1-0 (10) and open (11). The open output is decoded from the state alone. Matches may overlap, so a fresh attempt can begin on the press right after a failed or a successful one. The reset input is asynchronous and active low. It forces the machine to no progress at once, and its release is re-timed through a short synchronizer chain before the state register sees it.

Top module: `combo_lock_fsm`

## Requirements
- R1: While `rst_n` is low, `unlock_o` is 0 without waiting for a clock edge, and the state returns to no progress (00).
- R2: From no progress, presses 1, 0, 0 set `unlock_o` to 1 right after the clock edge that samples the third press, and not before.
- R3: `unlock_o` is 1 only in the open state (11) and changes only at a clock edge that samples `press_i` high.
- R4: On an edge where `press_i` is 0, the state and `unlock_o` hold, whatever the value of `b_i`.
- R5: From no progress, a 0 press stays in no progress, so any number of leading 0 presses still lets 1, 0, 0 open the lock.
- R6: From seen 1 (01), a 1 press stays in seen 1, so 1, 1, 0, 0 opens the lock.
- R7: From seen 1-0 (10), a 1 press goes back to seen 1, so 1, 0, 1, 0, 0 opens the lock.
- R8: From open (11), a 1 press goes to seen 1 and a 0 press goes to no progress, and either press clears `unlock_o`.
- R9: After `rst_n` rises, the presses sampled on the first two rising clock edges are ignored (synchronizer depth 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| press_i | input | 1 | One-cycle strobe, high for one cycle per button press |
| b_i | input | 1 | Button of the current press: 0 for button "0", 1 for button "1" |
| unlock_o | output | 1 | High while the last three presses were 1, 0, 0 |

## Verification
The bench feeds the plain sequence 1-0-0 and then sequences that each exercise one return arc. A repeated 1 checks that seen 1 holds. The pattern 1-0-1 checks the fall back from seen 1-0 to seen 1. Leading zeros check that no progress holds, and a press straight after an open checks both arcs out of the open state. Idle cycles with `b_i` toggling show that strobe gating, not the button bit, drives the state. The pattern 1-1-0-0 presented across the reset release tells a two-stage release apart from a one-stage one.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 2'b00,
    ST_ONE      = 2'b01,
    ST_ONE_ZERO = 2'b10,
    ST_OPEN     = 2'b11
  } lock_state_e;
endpackage

// File: rtl/combo_lock_rst_sync.sv
module combo_lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain_q;
  logic [MSB:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[MSB-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[MSB];
endmodule

// File: rtl/combo_lock_next.sv
module combo_lock_next
  import combo_lock_pkg::*;
(
  input  lock_state_e cur_state,
  input  logic        digit,
  output lock_state_e nxt_state
);
  // Both values of digit are covered in every state, with exactly one arc each.
  always_comb begin
    nxt_state = ST_IDLE;
    unique case (cur_state)
      ST_IDLE:     nxt_state = digit ? ST_ONE : ST_IDLE;
      ST_ONE:      nxt_state = digit ? ST_ONE : ST_ONE_ZERO;
      ST_ONE_ZERO: nxt_state = digit ? ST_ONE : ST_OPEN;
      ST_OPEN:     nxt_state = digit ? ST_ONE : ST_IDLE;
      default:     nxt_state = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/combo_lock_state_reg.sv
module combo_lock_state_reg
  import combo_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_sync_n,
  input  logic        en,
  input  lock_state_e d,
  output lock_state_e q
);
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q <= ST_IDLE;
    else if (en)     q <= d;
  end

  // R4: no strobe, no state change
  assert_hold_without_press_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable(q));
endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm
  import combo_lock_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic press_i,
  input  logic b_i,
  output logic unlock_o
);
  logic        rst_sync_n;
  lock_state_e state;
  lock_state_e state_nxt;

  combo_lock_rst_sync #(.STAGES(RST_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  combo_lock_next next_i (
    .cur_state (state),
    .digit     (b_i),
    .nxt_state (state_nxt)
  );

  combo_lock_state_reg reg_i (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .en         (press_i),
    .d          (state_nxt),
    .q          (state)
  );

  // Moore output: decoded from the current state only
  assign unlock_o = (state == ST_OPEN);

  // R2: the lock opens only on a sampled 0 press
  assert_open_needs_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(unlock_o) |-> $past(press_i && !b_i));

  // R3: the output moves only after a sampled press
  assert_output_moves_on_press_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !press_i |=> $stable(unlock_o));

  // R6, R7 and R8: any 1 press lands in seen 1
  assert_one_press_to_seen_one_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (press_i && b_i) |=> (state == ST_ONE));

  // R8: any press clears an open lock
  assert_open_cleared_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (unlock_o && press_i) |=> !unlock_o);
endmodule

// File: tb/combo_lock_fsm_tb_top.sv
`timescale 1ns/1ps
module combo_lock_fsm_tb_top;
  logic clk;
  logic rst_n;
  logic press;
  logic bit_in;
  logic unlock;
  int   n_chk  = 0;
  int   n_fail = 0;

  combo_lock_fsm dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .press_i  (press),
    .b_i      (bit_in),
    .unlock_o (unlock)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // Vector layout: [6] strobe, [5] button, [4] expected unlock after the edge, [3:0] requirement
  localparam int NVEC = 18;
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b0, 4'd2},  // R2 seen 1
    {1'b1, 1'b0, 1'b0, 4'd2},  // R2 seen 1-0
    {1'b0, 1'b1, 1'b0, 4'd4},  // R4 no strobe
    {1'b1, 1'b0, 1'b1, 4'd2},  // R2 open
    {1'b0, 1'b0, 1'b1, 4'd4},  // R4 hold open
    {1'b0, 1'b1, 1'b1, 4'd3},  // R3 button bit alone ignored
    {1'b1, 1'b1, 1'b0, 4'd8},  // R8 open -> seen 1
    {1'b1, 1'b1, 1'b0, 4'd6},  // R6 seen 1 holds
    {1'b1, 1'b0, 1'b0, 4'd6},
    {1'b1, 1'b1, 1'b0, 4'd7},  // R7 seen 1-0 -> seen 1
    {1'b1, 1'b0, 1'b0, 4'd7},
    {1'b1, 1'b0, 1'b1, 4'd7},  // R7 open after 1,0,1,0,0
    {1'b1, 1'b0, 1'b0, 4'd8},  // R8 open -> no progress
    {1'b1, 1'b0, 1'b0, 4'd5},  // R5 no progress holds
    {1'b1, 1'b0, 1'b0, 4'd5},
    {1'b1, 1'b1, 1'b0, 4'd5},
    {1'b1, 1'b0, 1'b0, 4'd5},
    {1'b1, 1'b0, 1'b1, 4'd5}   // R5 open after leading zeros
  };

  task automatic check(input logic exp, input int req, input string what);
    n_chk++;
    if (unlock !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: unlock_o=%0b expected %0b", req, what, unlock, exp);
    end
  endtask

  // Drive at a falling edge, then wait one full cycle; one rising edge falls in between
  task automatic apply(input logic p, input logic b);
    press  = p;
    bit_in = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    press  = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, 1, "held in reset");                        // R1
    rst_n = 1'b1;
    apply(1'b0, 1'b0);
    apply(1'b0, 1'b0);
    check(1'b0, 1, "after release");                        // R1

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][6], VEC[i][5]);
      check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R1: asynchronous assertion clears an open lock between edges
    check(1'b1, 1, "open before reset");
    #2 rst_n = 1'b0;
    #2 check(1'b0, 1, "async reset between edges");
    @(negedge clk);
    check(1'b0, 1, "reset held");

    // R9: the first two presses after release are dropped; 1,1,0,0 must not open
    rst_n = 1'b1;
    apply(1'b1, 1'b1);
    check(1'b0, 9, "release edge 1");
    apply(1'b1, 1'b1);
    check(1'b0, 9, "release edge 2");
    apply(1'b1, 1'b0);
    check(1'b0, 9, "first live press");
    apply(1'b1, 1'b0);
    check(1'b0, 9, "early presses ignored");
    apply(1'b1, 1'b1);
    apply(1'b1, 1'b0);
    check(1'b0, 2, "two of three digits");                  // R2
    apply(1'b1, 1'b0);
    check(1'b1, 2, "combination after release");            // R2
    apply(1'b0, 1'b0);
    check(1'b1, 4, "idle keeps open");                      // R4

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule